// File: doc/BRIEF.md
# Rotating Interleaved Multi-Bank Memory Crossbar

This block is a shared word memory split across sixteen single-port RAM banks and reached through sixteen requester ports. Consecutive 32-bit words sit in consecutive banks. A free-running four-bit rotation count gives each port a different bank on every clock. Port N faces bank (T + N) mod 16 on clock T. Because the mapping is a permutation, no two ports ever want the same bank in the same clock, and no arbiter is needed.

A requester raises its request with a byte address, a write flag, write data and byte enables, and holds them steady. It waits until the rotation brings the addressed bank to its port. The access then happens atomically in that clock. One clock later the port sees a single-cycle done strobe, together with the read data for a read. The wait depends only on the address, the port number and the rotation phase, so every requester can predict its own latency.

Top module: `rothub_mem`

## Requirements
- R1: The rotation count is 0 in the first clock after reset is released. A request issued in that clock by port 0 for a word in bank 0 completes with done one clock later.
- R2: The bank is selected by byte address bits [5:2]. The word within the bank is taken from the address bits above bit 5. Different word addresses refer to separate storage.
- R3: A request from port N to bank b, presented in clock T, is served after exactly (b − T − N) mod 16 clocks of waiting. The wait is never more than 15 clocks.
- R4: done is a one-clock pulse in the clock after the serving slot. For a read, the read data on rdata is valid in that same clock.
- R5: Byte-enable bit i writes byte i, which is data bits 8i+7 down to 8i. A byte whose enable bit is 0 keeps its old value.
- R6: When two ports access the same word, the accesses take effect in the order in which their slots occur.
- R7: All sixteen ports may issue requests in the same clock. Each request completes correctly, and no bank is ever driven by more than one port in a clock.
- R8: While reset is asserted, every done output is 0.
- R9: Byte address bits [1:0] have no effect on which word is accessed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_i | input | 16 | Request valid, one bit per port, held until done |
| we_i | input | 16 | Write flag per port (1 = write) |
| addr_i | input | 16*ADDR_W | Byte address per port, port N at bits [N*ADDR_W +: ADDR_W] |
| wdata_i | input | 16*32 | Write data per port |
| be_i | input | 16*4 | Byte enables per port |
| rdata_o | output | 16*32 | Read data per port, valid with done |
| done_o | output | 16 | One-clock completion strobe per port |

## Verification
For a request presented in a clock whose rotation phase is r, the bench predicts that done arrives exactly (b − r − N) mod 16 + 1 rising edges later. The bench keeps its own count of edges since reset. It samples done and rdata on falling edges, so it compares the edge count at which done appears with that prediction. A reference word array is updated in the predicted slot order, so reads that overlap writes to the same word are checked against the order the rotation imposes. Any done pulse beyond the first one, or on a port that has no request, counts as a failure.

// File: rtl/rothub_pkg.sv
package rothub_pkg;
    localparam int unsigned NPORT  = 16;
    localparam int unsigned SEL_W  = $clog2(NPORT);
    localparam int unsigned BYTES  = 4;
    localparam int unsigned DATA_W = BYTES * 8;
    localparam int unsigned OFS_W  = $clog2(BYTES);

    typedef logic [SEL_W-1:0] sel_t;

    typedef struct packed {
        logic done;
        sel_t sel;
    } port_st_t;
endpackage

// File: rtl/rothub_bank.sv
module rothub_bank
    import rothub_pkg::*;
#(
    parameter int unsigned WORDS = 64,
    parameter int unsigned IDX_W = $clog2(WORDS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en_i,
    input  logic              we_i,
    input  logic [IDX_W-1:0]  idx_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic [BYTES-1:0]  be_i,
    output logic [DATA_W-1:0] rdata_o
);
    logic [DATA_W-1:0] mem [WORDS];
    logic [DATA_W-1:0] rd_d, rd_q;

    always_ff @(posedge clk) begin
        if (en_i && we_i) begin
            for (int b = 0; b < BYTES; b++) begin
                if (be_i[b]) mem[idx_i][b*8 +: 8] <= wdata_i[b*8 +: 8];
            end
        end
    end

    always_comb begin
        rd_d = rd_q;
        if (en_i && !we_i) rd_d = mem[idx_i];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rd_q <= '0;
        else        rd_q <= rd_d;
    end

    assign rdata_o = rd_q;
endmodule

// File: rtl/rothub_port.sv
module rothub_port
    import rothub_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic req_i,
    input  sel_t bank_i,
    input  sel_t slot_i,
    output logic hit_o,
    output logic done_o,
    output sel_t sel_o
);
    port_st_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        hit_o     = req_i && (bank_i == slot_i);
        st_d.done = hit_o;
        if (hit_o) st_d.sel = slot_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign done_o = st_q.done;
    assign sel_o  = st_q.sel;

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o); // R4
    AST_DONE_AFTER_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> $past(req_i)); // R4
    AST_DONE_BANK: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (sel_o == $past(bank_i))); // R2
endmodule

// File: rtl/rothub_mem.sv
module rothub_mem
    import rothub_pkg::*;
#(
    parameter int unsigned WORDS  = 64,
    parameter int unsigned ADDR_W = $clog2(WORDS) + OFS_W + SEL_W
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [NPORT-1:0]        req_i,
    input  logic [NPORT-1:0]        we_i,
    input  logic [NPORT*ADDR_W-1:0] addr_i,
    input  logic [NPORT*DATA_W-1:0] wdata_i,
    input  logic [NPORT*BYTES-1:0]  be_i,
    output logic [NPORT*DATA_W-1:0] rdata_o,
    output logic [NPORT-1:0]        done_o
);
    localparam int unsigned IDX_W = ADDR_W - OFS_W - SEL_W;

    sel_t rot_d, rot_q;
    sel_t slot  [NPORT];
    sel_t pbank [NPORT];
    sel_t psel  [NPORT];
    logic [IDX_W-1:0]  pidx    [NPORT];
    logic [DATA_W-1:0] bank_rd [NPORT];
    logic [NPORT-1:0]  hit;
    logic [NPORT*OFS_W-1:0] unused_ofs;

    always_comb rot_d = sel_t'(rot_q + 1'b1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rot_q <= '0;
        else        rot_q <= rot_d;
    end

    for (genvar p = 0; p < NPORT; p++) begin : g_port
        assign pbank[p] = addr_i[p*ADDR_W + OFS_W +: SEL_W];
        assign pidx[p]  = addr_i[p*ADDR_W + OFS_W + SEL_W +: IDX_W];
        assign unused_ofs[p*OFS_W +: OFS_W] = addr_i[p*ADDR_W +: OFS_W];
        assign slot[p]  = sel_t'(rot_q + sel_t'(p));

        rothub_port u_port (
            .clk    (clk),
            .rst_n  (rst_n),
            .req_i  (req_i[p]),
            .bank_i (pbank[p]),
            .slot_i (slot[p]),
            .hit_o  (hit[p]),
            .done_o (done_o[p]),
            .sel_o  (psel[p])
        );

        assign rdata_o[p*DATA_W +: DATA_W] = bank_rd[psel[p]];
    end

    for (genvar k = 0; k < NPORT; k++) begin : g_bank
        sel_t              owner;
        logic              b_en, b_we;
        logic [IDX_W-1:0]  b_idx;
        logic [DATA_W-1:0] b_wd;
        logic [BYTES-1:0]  b_be;
        logic [NPORT-1:0]  taken;

        always_comb begin
            owner = sel_t'(sel_t'(k) - rot_q);
            b_en  = hit[owner];
            b_we  = we_i[owner];
            b_idx = pidx[owner];
            b_wd  = wdata_i[int'(owner)*DATA_W +: DATA_W];
            b_be  = be_i[int'(owner)*BYTES +: BYTES];
            for (int q = 0; q < NPORT; q++) begin
                taken[q] = hit[q] && (slot[q] == sel_t'(k));
            end
        end

        rothub_bank #(.WORDS(WORDS), .IDX_W(IDX_W)) u_bank (
            .clk     (clk),
            .rst_n   (rst_n),
            .en_i    (b_en),
            .we_i    (b_we),
            .idx_i   (b_idx),
            .wdata_i (b_wd),
            .be_i    (b_be),
            .rdata_o (bank_rd[k])
        );

        AST_BANK_ONE_OWNER: assert property (@(posedge clk) disable iff (!rst_n)
            $onehot0(taken)); // R7
    end
endmodule

// File: tb/rothub_mem_tb.sv
module rothub_mem_tb;
    localparam int NP = 16;
    localparam int AW = 12;
    localparam int NV = 12;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [NP-1:0]    req_i = '0;
    logic [NP-1:0]    we_i = '0;
    logic [NP*AW-1:0] addr_i = '0;
    logic [NP*32-1:0] wdata_i = '0;
    logic [NP*4-1:0]  be_i = '0;
    logic [NP*32-1:0] rdata_o;
    logic [NP-1:0]    done_o;

    rothub_mem #(.WORDS(64), .ADDR_W(AW)) u_dut (
        .clk(clk), .rst_n(rst_n), .req_i(req_i), .we_i(we_i), .addr_i(addr_i),
        .wdata_i(wdata_i), .be_i(be_i), .rdata_o(rdata_o), .done_o(done_o)
    );

    always #2 clk = ~clk;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    always @(posedge clk) if (rst_n) cyc <= cyc + 1;

    logic [31:0] model [1024];
    bit          act   [NP];
    logic        g_we  [NP];
    logic [AW-1:0] g_addr [NP];
    logic [31:0] g_wd  [NP];
    logic [3:0]  g_be  [NP];
    logic [31:0] exp_rd [NP];

    // port[52:49] we[48] addr[47:36] data[35:4] be[3:0]
    localparam logic [52:0] VEC [NV] = '{
        {4'd0,  1'b1, 12'h000, 32'h1111_1111, 4'hF},
        {4'd6,  1'b0, 12'h000, 32'h0,         4'h0},
        {4'd7,  1'b1, 12'h0A4, 32'hDEAD_BEEF, 4'hF},
        {4'd15, 1'b0, 12'h0A4, 32'h0,         4'h0},
        {4'd3,  1'b1, 12'h0A4, 32'h00AA_00CC, 4'h5},
        {4'd12, 1'b0, 12'h0A7, 32'h0,         4'h0},
        {4'd9,  1'b1, 12'hFFC, 32'hA5A5_A5A5, 4'hF},
        {4'd1,  1'b0, 12'hFFC, 32'h0,         4'h0},
        {4'd4,  1'b1, 12'h03C, 32'h1234_5678, 4'hF},
        {4'd2,  1'b0, 12'h03C, 32'h0,         4'h0},
        {4'd10, 1'b1, 12'h03D, 32'h0000_9900, 4'h2},
        {4'd13, 1'b0, 12'h03C, 32'h0,         4'h0}
    };

    task automatic chk(input bit ok, input string tag, input logic [31:0] a, input logic [31:0] e);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, a, e);
        end
    endtask

    task automatic clear_all();
        for (int p = 0; p < NP; p++) begin
            act[p] = 0; g_we[p] = 0; g_addr[p] = '0; g_wd[p] = '0; g_be[p] = '0;
        end
    endtask

    // Called at a falling edge; issues every active port and waits for all.
    task automatic go(input string tag);
        int r;
        int w [NP];
        bit pend [NP];
        r = cyc % 16;
        for (int p = 0; p < NP; p++) begin
            pend[p] = act[p];
            w[p] = (int'(g_addr[p][5:2]) - r - p + 48) % 16;
        end
        for (int ww = 0; ww < 16; ww++) begin
            for (int p = 0; p < NP; p++) begin
                if (pend[p] && w[p] == ww) begin
                    if (g_we[p]) begin
                        for (int b = 0; b < 4; b++)
                            if (g_be[p][b]) model[g_addr[p][AW-1:2]][b*8 +: 8] = g_wd[p][b*8 +: 8];
                    end else begin
                        exp_rd[p] = model[g_addr[p][AW-1:2]];
                    end
                end
            end
        end
        for (int p = 0; p < NP; p++) begin
            req_i[p] = act[p];
            we_i[p]  = g_we[p];
            addr_i[p*AW +: AW]  = g_addr[p];
            wdata_i[p*32 +: 32] = g_wd[p];
            be_i[p*4 +: 4]      = g_be[p];
        end
        for (int k = 1; k <= 18; k++) begin
            @(negedge clk);
            for (int p = 0; p < NP; p++) begin
                if (done_o[p]) begin
                    if (!pend[p]) begin
                        chk(0, {tag, " R4 stray or repeated done"}, 32'(p), 32'hFFFF_FFFF);
                    end else begin
                        chk(k == w[p] + 1, {tag, " R3 wait"}, 32'(k), 32'(w[p] + 1));
                        if (!g_we[p])
                            chk(rdata_o[p*32 +: 32] === exp_rd[p], {tag, " R4 read data"},
                                rdata_o[p*32 +: 32], exp_rd[p]);
                        pend[p] = 0;
                        req_i[p] = 1'b0;
                    end
                end
            end
        end
        for (int p = 0; p < NP; p++) begin
            if (pend[p]) chk(0, {tag, " R3 no done"}, 32'(p), 32'(w[p] + 1));
            req_i[p] = 1'b0;
        end
        clear_all();
    endtask

    initial begin
        #(4 * 200000);
        errors++;
        checks++;
        $display("FAIL watchdog R7 run did not finish actual=hung expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        clear_all();
        for (int i = 0; i < 1024; i++) model[i] = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(done_o == '0, "R8 done low in reset", 32'(done_o), 32'h0);
        rst_n = 1'b1;

        // R1: first clock after reset, port 0, bank 0 -> wait 0
        act[0] = 1; g_we[0] = 1; g_addr[0] = 12'h000; g_wd[0] = 32'h0; g_be[0] = 4'hF;
        go("R1 first slot");

        // table: R2 R5 R9 with varied ports and phases
        for (int v = 0; v < NV; v++) begin
            int p;
            @(negedge clk);
            p = int'(VEC[v][52:49]);
            act[p] = 1; g_we[p] = VEC[v][48]; g_addr[p] = VEC[v][47:36];
            g_wd[p] = VEC[v][35:4]; g_be[p] = VEC[v][3:0];
            go("R2 R5 R9 table");
        end

        // R3: longest wait (15) and zero wait
        @(negedge clk);
        act[6] = 1; g_we[6] = 1; g_wd[6] = 32'h7777_0006; g_be[6] = 4'hF;
        g_addr[6] = {6'd20, 4'((cyc % 16 + 6 - 1) % 16), 2'b00};
        go("R3 max wait");
        @(negedge clk);
        act[11] = 1; g_we[11] = 0;
        g_addr[11] = {6'd20, 4'((cyc % 16 + 11) % 16), 2'b00};
        go("R3 zero wait");

        // R7: all ports write at once, then all read at once
        @(negedge clk);
        for (int p = 0; p < NP; p++) begin
            act[p] = 1; g_we[p] = 1; g_be[p] = 4'hF; g_wd[p] = 32'hC0DE_0000 + 32'(p);
            g_addr[p] = {6'(p + 5), 4'((p * 5) % 16), 2'b00};
        end
        go("R7 all write");
        @(negedge clk);
        for (int p = 0; p < NP; p++) begin
            int q;
            q = (p + 3) % 16;
            act[p] = 1; g_we[p] = 0;
            g_addr[p] = {6'(q + 5), 4'((q * 5) % 16), 2'b00};
        end
        go("R7 all read");

        // R6: same word, writer and reader on different ports
        @(negedge clk);
        act[2] = 1; g_we[2] = 1; g_wd[2] = 32'h55AA_33CC; g_be[2] = 4'hF; g_addr[2] = 12'h100;
        act[11] = 1; g_we[11] = 0; g_addr[11] = 12'h100;
        go("R6 order a");
        @(negedge clk);
        @(negedge clk);
        act[11] = 1; g_we[11] = 1; g_wd[11] = 32'h0BAD_F00D; g_be[11] = 4'hF; g_addr[11] = 12'h100;
        act[2] = 1; g_we[2] = 0; g_addr[2] = 12'h100;
        go("R6 order b");

        repeat (2) @(negedge clk);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule